// File: doc/BRIEF.md
# Receiver-Enable Seed and Delay Calculator

This block does the arithmetic for hardware-assisted receiver-enable training on a memory channel. It has two passes. Both walk the byte lanes in a fixed order, one lane for each accepted input cycle.

In the seed pass, each lane's write-leveling delay is added to a platform estimate. The sum is then split into a gross count of 32-step units and a fine remainder. From these the block produces three values:
- the preamble seed word for the PHY;
- the receiver-enable seed;
- a compact per-lane gross offset, which it keeps in internal storage.

In the finalize pass, the block takes the value the PHY trained for each lane and adds back that lane's stored gross offset plus one unit interval (32 steps). The result is the lane's final receiver-enable delay. The block also keeps a running maximum across the lanes of the pass. When the last lane is presented, the final maximum is valid and `done` pulses. A control agent then uses that maximum to set read latency.

Top module: `rxen_seed_calc`

## Requirements
- R1: After a synchronous active-low reset, out_valid and done are 0, out_lane is 0 and max_dly is 0.
- R2: In seed mode (mode_final=0) the sum T = wrdqs_dly + estimate is formed at 11 bits without wrap. rxen_seed equals T with its five low bits cleared, that is gross*32 where gross = T/32.
- R3: The estimate is 0x3B unless est_ovr_en is 1, in which case est_ovr replaces it for that lane.
- R4: The pre-gross value P is 1 when gross is odd and 2 when gross is even. phy_seed equals P*32 + (T mod 32).
- R5: In finalize mode (mode_final=1), final_dly equals phy_trained[7:0] + ((gross−P) mod 16)*32 + 32. Here gross and P are the values that the most recent seed pass computed for the same lane. Bits 9:8 of phy_trained have no effect.
- R6: In finalize mode, max_dly is updated on each output to the largest final_dly seen since lane 0 of the current finalize pass. The maximum starts from 0 at lane 0. Seed-mode lanes leave max_dly unchanged.
- R7: Each accepted input produces exactly one output one clock later, with out_lane counting 0 to 7 and then wrapping to 0. done is 1 only together with the output for lane 7.
- R8: A cycle with in_valid=0 produces no output (out_valid=0, done=0). It also leaves the lane position, the stored offsets and max_dly unchanged, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | One lane's operands are present |
| mode_final | input | 1 | 0 = seed pass, 1 = finalize pass |
| wrdqs_dly | input | 10 | Write-leveling delay of the lane (seed pass) |
| est_ovr_en | input | 1 | Use est_ovr instead of the default estimate |
| est_ovr | input | 10 | Per-lane platform estimate override |
| phy_trained | input | 10 | PHY-trained preamble delay of the lane (finalize pass) |
| out_valid | output | 1 | Result registers hold a new lane result |
| out_lane | output | 3 | Lane index of the result |
| phy_seed | output | 10 | Preamble seed word for the PHY |
| rxen_seed | output | 11 | Receiver-enable seed (gross*32) |
| final_dly | output | 10 | Final receiver-enable delay |
| max_dly | output | 10 | Running maximum of final delays in the finalize pass |
| done | output | 1 | Last lane of a pass is on the outputs |

## Verification
The bench runs 64 seed/finalize pass pairs, using write delays and overrides that cover the edge cases:
- Sums with gross 0 show whether the gross−P offset wraps modulo 16 correctly.
- Sums near 0x7FE show whether the 11-bit sum truncates.
- Alternating odd and even gross values show a reversed parity choice.

PHY-trained values are given nonzero upper bits to show whether they leak into the final delay. The lane values are arranged so the maximum falls on early, middle and late lanes, which separates a maximum that resets at lane 0 from one that carries over between passes. Idle cycles carrying junk operands and a flipped mode are placed in the middle of passes, to confirm that they neither advance the lane position nor disturb stored state.

// File: rtl/rxen_pkg.sv
// Shared definitions for the receiver-enable seed/delay calculator.
package rxen_pkg;
    // Operating pass selected by mode_final.
    typedef enum logic {
        MODE_SEED  = 1'b0,
        MODE_FINAL = 1'b1
    } calc_mode_e;
endpackage

// File: rtl/rxen_seed_unit.sv
// Seed arithmetic for one lane (combinational).
// Forms T = write delay + estimate without wrap, then splits T into gross and fine.
// Picks pre-gross by the parity of gross and returns the PHY seed word, the
// receiver-enable seed and the gross offset modulo 2^OFS_W.
// Assumes DLY_W >= FINE_W + 2.
module rxen_seed_unit #(
    parameter int DLY_W       = 10,
    parameter int FINE_W      = 5,
    parameter int OFS_W       = 4,
    parameter int EST_DEFAULT = 59
) (
    input  logic [DLY_W-1:0] wrdqs,
    input  logic             ovr_en,
    input  logic [DLY_W-1:0] ovr_val,
    output logic [DLY_W-1:0] phy_seed,
    output logic [DLY_W:0]   rxen_seed,
    output logic [OFS_W-1:0] ofs_code
);
    localparam int GROSS_W = DLY_W + 1 - FINE_W;
    localparam int PAD_W   = DLY_W - FINE_W - 2;
    localparam logic [DLY_W-1:0] EST_DEF_V = DLY_W'(EST_DEFAULT);

    logic [DLY_W-1:0]   est;
    logic [DLY_W:0]     total;
    logic [GROSS_W-1:0] gross;
    logic [FINE_W-1:0]  fine;
    logic [1:0]         pre;
    logic [GROSS_W-1:0] gross_less_pre;

    // Choose the estimate, split the sum and derive the three seed values.
    always_comb begin
        est            = ovr_en ? ovr_val : EST_DEF_V;
        total          = {1'b0, wrdqs} + {1'b0, est};
        gross          = total[DLY_W:FINE_W];
        fine           = total[FINE_W-1:0];
        pre            = gross[0] ? 2'd1 : 2'd2;
        phy_seed       = {{PAD_W{1'b0}}, pre, fine};
        rxen_seed      = {gross, {FINE_W{1'b0}}};
        gross_less_pre = gross - {{(GROSS_W-2){1'b0}}, pre};
        ofs_code       = gross_less_pre[OFS_W-1:0];
    end
endmodule

// File: rtl/rxen_final_unit.sv
// Final delay arithmetic for one lane (combinational).
// Keeps the low KEEP_W bits of the PHY-trained value, adds the stored gross
// offset placed at bit FINE_W, and adds one unit interval (2^FINE_W).
// Assumes KEEP_W and OFS_W+FINE_W are both below DLY_W, so the sum cannot wrap.
module rxen_final_unit #(
    parameter int DLY_W  = 10,
    parameter int FINE_W = 5,
    parameter int OFS_W  = 4,
    parameter int KEEP_W = 8
) (
    input  logic [DLY_W-1:0] phy_trained,
    input  logic [OFS_W-1:0] ofs_code,
    output logic [DLY_W-1:0] final_dly
);
    localparam logic [DLY_W-1:0] ONE_UI = DLY_W'(1 << FINE_W);

    logic [DLY_W-1:0] kept;
    logic [DLY_W-1:0] ofs_val;

    // Recombine the trained value with the stored offset and one UI.
    always_comb begin
        kept      = {{(DLY_W-KEEP_W){1'b0}}, phy_trained[KEEP_W-1:0]};
        ofs_val   = {{(DLY_W-OFS_W-FINE_W){1'b0}}, ofs_code, {FINE_W{1'b0}}};
        final_dly = kept + ofs_val + ONE_UI;
    end
endmodule

// File: rtl/rxen_lane_seq.sv
// Lane sequencer: counts accepted lanes 0..LANES-1 and wraps to 0.
// Flags the last lane. Holds its count on cycles without a step.
module rxen_lane_seq #(
    parameter int LANES  = 8,
    parameter int LANE_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    output logic [LANE_W-1:0] lane,
    output logic              last
);
    localparam logic [LANE_W-1:0] LAST_IDX = LANE_W'(LANES - 1);

    assign last = (lane == LAST_IDX);

    // Advance the lane index on each accepted lane.
    always_ff @(posedge clk) begin
        if (!rst_n)    lane <= '0;
        else if (step) lane <= last ? '0 : lane + 1'b1;
    end
endmodule

// File: rtl/rxen_seed_calc.sv
// Receiver-enable seed and delay calculator (top).
// Seed pass: for each lane, computes the seeds and stores that lane's gross offset.
// Finalize pass: for each lane, recombines the PHY result with the stored offset
// and tracks the maximum across lanes.
// Outputs are registered, with one cycle of latency.
// Assumes mode_final stays constant for all lanes of one pass.
module rxen_seed_calc
    import rxen_pkg::*;
#(
    parameter int LANES       = 8,
    parameter int LANE_W      = $clog2(LANES),
    parameter int DLY_W       = 10,
    parameter int FINE_W      = 5,
    parameter int EST_DEFAULT = 59
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              mode_final,
    input  logic [DLY_W-1:0]  wrdqs_dly,
    input  logic              est_ovr_en,
    input  logic [DLY_W-1:0]  est_ovr,
    input  logic [DLY_W-1:0]  phy_trained,
    output logic              out_valid,
    output logic [LANE_W-1:0] out_lane,
    output logic [DLY_W-1:0]  phy_seed,
    output logic [DLY_W:0]    rxen_seed,
    output logic [DLY_W-1:0]  final_dly,
    output logic [DLY_W-1:0]  max_dly,
    output logic              done
);
    localparam int OFS_W  = 4;
    localparam int KEEP_W = 8;

    calc_mode_e        mode;
    logic [LANE_W-1:0] lane;
    logic              lane_last;
    logic [DLY_W-1:0]  seed_phy_c;
    logic [DLY_W:0]    seed_rx_c;
    logic [OFS_W-1:0]  ofs_new;
    logic [OFS_W-1:0]  ofs_cur;
    logic [DLY_W-1:0]  final_c;
    logic [DLY_W-1:0]  max_next;
    logic [OFS_W-1:0]  ofs_mem [LANES];

    assign mode = calc_mode_e'(mode_final);

    rxen_lane_seq #(.LANES(LANES), .LANE_W(LANE_W)) u_seq (
        .clk  (clk),
        .rst_n(rst_n),
        .step (in_valid),
        .lane (lane),
        .last (lane_last)
    );

    rxen_seed_unit #(
        .DLY_W(DLY_W), .FINE_W(FINE_W), .OFS_W(OFS_W), .EST_DEFAULT(EST_DEFAULT)
    ) u_seed (
        .wrdqs    (wrdqs_dly),
        .ovr_en   (est_ovr_en),
        .ovr_val  (est_ovr),
        .phy_seed (seed_phy_c),
        .rxen_seed(seed_rx_c),
        .ofs_code (ofs_new)
    );

    assign ofs_cur = ofs_mem[lane];

    rxen_final_unit #(
        .DLY_W(DLY_W), .FINE_W(FINE_W), .OFS_W(OFS_W), .KEEP_W(KEEP_W)
    ) u_final (
        .phy_trained(phy_trained),
        .ofs_code   (ofs_cur),
        .final_dly  (final_c)
    );

    // Next running maximum: restart at lane 0, otherwise keep the larger value.
    always_comb begin
        if (lane == '0)            max_next = final_c;
        else if (final_c > max_dly) max_next = final_c;
        else                        max_next = max_dly;
    end

    // Per-lane gross offset storage, written during the seed pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LANES; i++) ofs_mem[i] <= '0;
        end else if (in_valid && mode == MODE_SEED) begin
            ofs_mem[lane] <= ofs_new;
        end
    end

    // Result registers for the lane just accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_lane  <= '0;
            phy_seed  <= '0;
            rxen_seed <= '0;
            final_dly <= '0;
            max_dly   <= '0;
            done      <= 1'b0;
        end else begin
            out_valid <= in_valid;
            done      <= in_valid && lane_last;
            if (in_valid) begin
                out_lane <= lane;
                if (mode == MODE_SEED) begin
                    phy_seed  <= seed_phy_c;
                    rxen_seed <= seed_rx_c;
                    final_dly <= '0;
                end else begin
                    phy_seed  <= '0;
                    rxen_seed <= '0;
                    final_dly <= final_c;
                    max_dly   <= max_next;
                end
            end
        end
    end

    // R7: an output only ever follows an accepted input.
    a_r7_out_follows_in: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));
    // R7: done only accompanies the last lane.
    a_r7_done_last_lane: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (out_valid && out_lane == LANE_W'(LANES - 1)));
    // R4: the pre-gross bits of the PHY seed agree with the parity of the seed gross.
    a_r4_pre_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(mode_final) == 1'b0) |->
        (phy_seed[FINE_W] == rxen_seed[FINE_W] && phy_seed[FINE_W+1] == !rxen_seed[FINE_W]));
    // R2: the receiver-enable seed is a whole number of gross units.
    a_r2_seed_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (rxen_seed[FINE_W-1:0] == '0));
    // R5: every final delay includes at least one UI.
    a_r5_final_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(mode_final)) |-> (final_dly >= DLY_W'(1 << FINE_W)));
    // R6: the maximum never falls below the current final delay.
    a_r6_max_covers: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(mode_final)) |-> (max_dly >= final_dly));
    // R8: an idle cycle leaves the maximum untouched.
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(max_dly));
endmodule

// File: tb/rxen_seed_calc_tb.sv
module rxen_seed_calc_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 8;
    localparam int PASSES     = 64;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid;
    logic       mode_final;
    logic [9:0] wrdqs_dly;
    logic       est_ovr_en;
    logic [9:0] est_ovr;
    logic [9:0] phy_trained;
    logic       out_valid;
    logic [2:0] out_lane;
    logic [9:0] phy_seed;
    logic [10:0] rxen_seed;
    logic [9:0] final_dly;
    logic [9:0] max_dly;
    logic       done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int exp_ofs [LANES];

    always #(CLK_PERIOD/2) clk = ~clk;

    rxen_seed_calc u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_final(mode_final),
        .wrdqs_dly(wrdqs_dly), .est_ovr_en(est_ovr_en), .est_ovr(est_ovr),
        .phy_trained(phy_trained), .out_valid(out_valid), .out_lane(out_lane),
        .phy_seed(phy_seed), .rxen_seed(rxen_seed), .final_dly(final_dly),
        .max_dly(max_dly), .done(done)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One accepted lane: drive at the falling edge, sample at the next falling edge.
    task automatic drive_lane(input logic mf, input int w, input logic oe, input int ov, input int ph);
        in_valid    = 1'b1;
        mode_final  = mf;
        wrdqs_dly   = 10'(w);
        est_ovr_en  = oe;
        est_ovr     = 10'(ov);
        phy_trained = 10'(ph);
        @(posedge clk);
        @(negedge clk);
        in_valid    = 1'b0;
    endtask

    // Idle cycle with junk operands; nothing may change (R8).
    task automatic idle_cycle(input int prev_max);
        in_valid    = 1'b0;
        mode_final  = ~mode_final;
        wrdqs_dly   = 10'h3FF;
        est_ovr_en  = 1'b1;
        est_ovr     = 10'h155;
        phy_trained = 10'h2AA;
        @(posedge clk);
        @(negedge clk);
        chk("R8", "idle out_valid", int'(out_valid), 0);
        chk("R8", "idle done", int'(done), 0);
        chk("R8", "idle max_dly", int'(max_dly), prev_max);
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; mode_final = 1'b0;
        wrdqs_dly = '0; est_ovr_en = 1'b0; est_ovr = '0; phy_trained = '0;
        repeat (3) @(negedge clk);
        chk("R1", "reset out_valid", int'(out_valid), 0);
        chk("R1", "reset done", int'(done), 0);
        chk("R1", "reset out_lane", int'(out_lane), 0);
        chk("R1", "reset max_dly", int'(max_dly), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int p = 0; p < PASSES; p++) begin
            int run_max;
            run_max = int'(max_dly);
            // Seed pass (R2, R3, R4, R7)
            for (int l = 0; l < LANES; l++) begin
                int w, est, ov, tot, gr, fn, pre;
                logic oe;
                if (p == 0)            begin w = 0;     oe = 1'b1; ov = 0; end
                else if (p == PASSES-1) begin w = 1023; oe = 1'b1; ov = 1023; end
                else begin
                    w  = (p * 16 + l * 37) % 1024;
                    oe = (p % 3 == 1);
                    ov = (p * 29 + l * 71) % 1024;
                end
                est = oe ? ov : 59;
                tot = w + est;
                gr  = tot / 32;
                fn  = tot % 32;
                pre = (gr % 2 == 1) ? 1 : 2;
                exp_ofs[l] = (gr - pre) & 15;
                drive_lane(1'b0, w, oe, ov, 0);
                chk("R7", "seed out_valid", int'(out_valid), 1);
                chk("R7", "seed lane", int'(out_lane), l);
                chk("R7", "seed done", int'(done), (l == LANES-1) ? 1 : 0);
                chk("R2", "rxen_seed", int'(rxen_seed), gr * 32);
                chk("R4", "phy_seed", int'(phy_seed), pre * 32 + fn);
                if (oe) chk("R3", "override seed", int'(rxen_seed), gr * 32);
                else    chk("R3", "default seed", int'(phy_seed), pre * 32 + fn);
                chk("R6", "seed max hold", int'(max_dly), run_max);
                if (p % 2 == 1 && l == 3) idle_cycle(run_max);
            end
            // Finalize pass (R5, R6, R7)
            for (int l = 0; l < LANES; l++) begin
                int ph, fin;
                ph  = (p * 53 + l * 97 + ((l == p % LANES) ? 200 : 0)) % 1024;
                fin = (ph & 255) + exp_ofs[l] * 32 + 32;
                if (l == 0 || fin > run_max) run_max = fin;
                drive_lane(1'b1, 1023, 1'b1, 1023, ph);
                chk("R7", "final lane", int'(out_lane), l);
                chk("R7", "final done", int'(done), (l == LANES-1) ? 1 : 0);
                chk("R5", "final_dly", int'(final_dly), fin);
                chk("R6", "max_dly", int'(max_dly), run_max);
                if (p % 4 == 2 && l == 5) idle_cycle(run_max);
            end
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule